// File: doc/BRIEF.md
# Privilege-Aware Virtual Segment Decoder

This block sorts each virtual address into a segment class before any translation lookup takes place. It works out the effective privilege from the processor status bits, picks the address-width mode that belongs to that privilege, and then decides which of three outcomes applies. The address can fall in an unmapped window and get a physical address at once. It can need a lookup in the translation buffer. Or it can be an illegal access that raises an address-error exception.

A request is a single cycle with `req_valid` high. One clock later the block returns a registered result with a one-cycle `rsp_valid` pulse. The translation-request strobe and the exception strobe only rise together with that pulse, so downstream logic can use them directly as enables. A no-exception request flag lets probe-style accesses learn that an access is illegal without raising the exception path.

Top module: `vseg_classify`

## Requirements
- R1: The effective privilege `rsp_priv` equals the two-bit mode field `st_ksu` (00 kernel, 01 supervisor, 10 user, 11 handled like user). It is forced to 00 when `st_exl` or `st_erl` is set.
- R2: `rsp_wide` takes `st_kx` at kernel privilege, `st_sx` at supervisor privilege and `st_ux` otherwise.
- R3: An address whose bits 63:62 equal 2'b10 is unmapped at every privilege: `rsp_direct` and `rsp_writable` are 1 and `rsp_paddr` holds the address bits 43:0.
- R4: Any address not above 0x7FFFFFFF gives `rsp_tlb_req`=1 at every privilege.
- R5: An address with bits 63:32 all zero and bit 31 set is sign-extended to 64 bits before the range checks. In kernel mode 0x80000000 therefore yields a direct hit with physical address 0.
- R6: At kernel privilege, a sign-extended address from 0xFFFFFFFF80000000 to 0xFFFFFFFFBFFFFFFF is unmapped and writable, with `rsp_paddr` equal to the address ANDed with 0x1FFFFFFF.
- R7: At kernel privilege, every other address above 0x7FFFFFFF that R3 does not cover gives `rsp_tlb_req`=1.
- R8: At non-kernel privilege, an address above 0x7FFFFFFF that R3 does not cover sets `rsp_fail` and `rsp_exc`. The code is 5'd4 for a read and 5'd5 for a write, and `rsp_badaddr` holds the sign-extended address.
- R9: With `req_noexc` set, an illegal access sets `rsp_fail` only: `rsp_exc` is 0, `rsp_exc_code` is 0 and `rsp_badaddr` is 0.
- R10: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. With it, exactly one of `rsp_tlb_req`, `rsp_direct` and `rsp_fail` is 1. Without it, all strobes are 0. `rsp_paddr` and `rsp_writable` are 0 when the result is not a direct hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 64 | Virtual address to classify |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_noexc | input | 1 | Report failure without raising an exception |
| st_ksu | input | 2 | Status mode field |
| st_exl | input | 1 | Exception-level status bit |
| st_erl | input | 1 | Error-level status bit |
| st_ux | input | 1 | 64-bit mode enable, user |
| st_sx | input | 1 | 64-bit mode enable, supervisor |
| st_kx | input | 1 | 64-bit mode enable, kernel |
| rsp_valid | output | 1 | Result pulse |
| rsp_priv | output | 2 | Effective privilege |
| rsp_wide | output | 1 | 64-bit addressing flag |
| rsp_tlb_req | output | 1 | Translation lookup strobe |
| rsp_direct | output | 1 | Unmapped hit |
| rsp_writable | output | 1 | Direct page is read/write |
| rsp_paddr | output | PA_W (44) | Physical address for a direct hit |
| rsp_fail | output | 1 | Access failed |
| rsp_exc | output | 1 | Address-error exception strobe |
| rsp_exc_code | output | EXC_W (5) | Exception code |
| rsp_badaddr | output | 64 | Faulting (sign-extended) address |

## Verification
The hardest case to reach is the sign-extension path: a short address with a zero upper half and bit 31 set must land in the kernel direct window, or in an address error at lower privilege. Plain random 64-bit values almost never produce that pattern. The stimulus therefore first picks an address family (low, short-negative, kernel window, direct physical, other high) and only then randomises the bits inside it. The status bits are drawn separately, including mode field 11 and the override bits, so every privilege meets every family.

// File: rtl/vseg_pkg.sv
package vseg_pkg;
   typedef enum logic [1:0] {
      SEG_TLB     = 2'd0,
      SEG_DIRECT  = 2'd1,
      SEG_ILLEGAL = 2'd2
   } seg_cls_e;

   localparam logic [1:0] PRIV_KERNEL = 2'b00;
   localparam logic [1:0] PRIV_SUPER  = 2'b01;
   localparam logic [1:0] PRIV_USER   = 2'b10;

   localparam int VA_W   = 64;
   localparam int XP_W   = 44;
   localparam int KSEG_W = 29;
endpackage

// File: rtl/vseg_priv.sv
module vseg_priv
   import vseg_pkg::*;
(
   input  logic [1:0] ksu,
   input  logic       exl,
   input  logic       erl,
   input  logic       ux,
   input  logic       sx,
   input  logic       kx,
   output logic [1:0] priv,
   output logic       is_kernel,
   output logic       wide
);
   always_comb begin
      priv      = (exl || erl) ? PRIV_KERNEL : ksu;
      is_kernel = (priv == PRIV_KERNEL);
      unique case (priv)
         PRIV_KERNEL: wide = kx;
         PRIV_SUPER:  wide = sx;
         default:     wide = ux;
      endcase
   end
endmodule

// File: rtl/vseg_range.sv
module vseg_range
   import vseg_pkg::*;
(
   input  logic [VA_W-1:0] vaddr,
   input  logic            is_kernel,
   output seg_cls_e        cls,
   output logic [VA_W-1:0] ext_addr,
   output logic [XP_W-1:0] paddr_raw
);
   localparam int HALF = VA_W / 2;

   logic short_neg;
   logic xphys_hit;
   logic low_hit;
   logic kwin_hit;

   always_comb begin
      short_neg = (vaddr[VA_W-1:HALF] == '0) && vaddr[HALF-1];
      ext_addr  = short_neg ? {{HALF{1'b1}}, vaddr[HALF-1:0]} : vaddr;
      xphys_hit = (vaddr[VA_W-1 -: 2] == 2'b10);
      low_hit   = (vaddr[VA_W-1:HALF-1] == '0);
      kwin_hit  = (ext_addr[VA_W-1:HALF] == '1) && (ext_addr[HALF-1 -: 2] == 2'b10);

      cls       = SEG_ILLEGAL;
      paddr_raw = '0;
      if (xphys_hit) begin
         cls       = SEG_DIRECT;
         paddr_raw = vaddr[XP_W-1:0];
      end else if (low_hit) begin
         cls = SEG_TLB;
      end else if (is_kernel) begin
         if (kwin_hit) begin
            cls       = SEG_DIRECT;
            paddr_raw = {{(XP_W-KSEG_W){1'b0}}, ext_addr[KSEG_W-1:0]};
         end else begin
            cls = SEG_TLB;
         end
      end
   end
endmodule

// File: rtl/vseg_classify.sv
module vseg_classify
   import vseg_pkg::*;
#(
   parameter int PA_W      = 44,
   parameter int EXC_W     = 5,
   parameter int EXC_LOAD  = 4,
   parameter int EXC_STORE = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [63:0]      req_vaddr,
   input  logic             req_write,
   input  logic             req_noexc,
   input  logic [1:0]       st_ksu,
   input  logic             st_exl,
   input  logic             st_erl,
   input  logic             st_ux,
   input  logic             st_sx,
   input  logic             st_kx,
   output logic             rsp_valid,
   output logic [1:0]       rsp_priv,
   output logic             rsp_wide,
   output logic             rsp_tlb_req,
   output logic             rsp_direct,
   output logic             rsp_writable,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic             rsp_fail,
   output logic             rsp_exc,
   output logic [EXC_W-1:0] rsp_exc_code,
   output logic [63:0]      rsp_badaddr
);
   localparam int CODE_MAX = (1 << EXC_W) - 1;

   if (PA_W < XP_W || PA_W > VA_W) begin : g_bad_pa
      $error("vseg_classify: PA_W must lie between 44 and 64");
   end
   if (EXC_LOAD == EXC_STORE || EXC_LOAD == 0 || EXC_STORE == 0 ||
       EXC_LOAD > CODE_MAX || EXC_STORE > CODE_MAX) begin : g_bad_code
      $error("vseg_classify: exception codes must be distinct, nonzero and fit EXC_W");
   end

   logic [1:0]      priv;
   logic            is_kernel;
   logic            wide;
   seg_cls_e        cls;
   logic [VA_W-1:0] ext_addr;
   logic [XP_W-1:0] paddr_raw;
   logic [PA_W-1:0] paddr_fit;

   vseg_priv u_priv (
      .ksu       (st_ksu),
      .exl       (st_exl),
      .erl       (st_erl),
      .ux        (st_ux),
      .sx        (st_sx),
      .kx        (st_kx),
      .priv      (priv),
      .is_kernel (is_kernel),
      .wide      (wide)
   );

   vseg_range u_range (
      .vaddr     (req_vaddr),
      .is_kernel (is_kernel),
      .cls       (cls),
      .ext_addr  (ext_addr),
      .paddr_raw (paddr_raw)
   );

   if (PA_W == XP_W) begin : g_pa_exact
      assign paddr_fit = paddr_raw;
   end else begin : g_pa_pad
      assign paddr_fit = {{(PA_W-XP_W){1'b0}}, paddr_raw};
   end

   logic             go_tlb;
   logic             go_direct;
   logic             go_fail;
   logic             raise;
   logic [EXC_W-1:0] code_n;

   always_comb begin
      go_tlb    = (cls == SEG_TLB);
      go_direct = (cls == SEG_DIRECT);
      go_fail   = (cls == SEG_ILLEGAL);
      raise     = go_fail && !req_noexc;
      code_n    = '0;
      if (raise) code_n = req_write ? EXC_W'(EXC_STORE) : EXC_W'(EXC_LOAD);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_tlb_req  <= 1'b0;
         rsp_direct   <= 1'b0;
         rsp_fail     <= 1'b0;
         rsp_exc      <= 1'b0;
         rsp_priv     <= '0;
         rsp_wide     <= 1'b0;
         rsp_writable <= 1'b0;
         rsp_paddr    <= '0;
         rsp_exc_code <= '0;
         rsp_badaddr  <= '0;
      end else begin
         rsp_valid   <= req_valid;
         rsp_tlb_req <= req_valid && go_tlb;
         rsp_direct  <= req_valid && go_direct;
         rsp_fail    <= req_valid && go_fail;
         rsp_exc     <= req_valid && raise;
         if (req_valid) begin
            rsp_priv     <= priv;
            rsp_wide     <= wide;
            rsp_writable <= go_direct;
            rsp_paddr    <= go_direct ? paddr_fit : '0;
            rsp_exc_code <= code_n;
            rsp_badaddr  <= raise ? ext_addr : '0;
         end
      end
   end
endmodule

// File: rtl/vseg_chk.sv
module vseg_chk #(
   parameter int EXC_W     = 5,
   parameter int EXC_LOAD  = 4,
   parameter int EXC_STORE = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [63:0]      req_vaddr,
   input logic             req_write,
   input logic             req_noexc,
   input logic             st_exl,
   input logic             st_erl,
   input logic             rsp_valid,
   input logic [1:0]       rsp_priv,
   input logic             rsp_tlb_req,
   input logic             rsp_direct,
   input logic             rsp_fail,
   input logic             rsp_exc,
   input logic [EXC_W-1:0] rsp_exc_code
);
   AST_PULSE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == $past(req_valid)); // R10
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $countones({rsp_tlb_req, rsp_direct, rsp_fail}) == 1); // R10
   AST_STROBES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !rsp_tlb_req && !rsp_exc && !rsp_direct && !rsp_fail); // R10
   AST_OVERRIDE_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && $past(st_exl || st_erl) |-> rsp_priv == 2'b00); // R1
   AST_LOW_GOES_TLB: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && $past(req_vaddr[63:31] == 33'd0) |-> rsp_tlb_req); // R4
   AST_KERNEL_NEVER_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_priv == 2'b00 |-> !rsp_fail); // R7
   AST_CODE_BY_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_exc |-> rsp_exc_code == ($past(req_write) ? EXC_W'(EXC_STORE) : EXC_W'(EXC_LOAD))); // R8
   AST_QUIET_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && $past(req_noexc) |-> !rsp_exc && rsp_exc_code == '0); // R9
endmodule

bind vseg_classify vseg_chk #(
   .EXC_W     (EXC_W),
   .EXC_LOAD  (EXC_LOAD),
   .EXC_STORE (EXC_STORE)
) u_chk (.*);

// File: tb/sim_vseg_classify.sv
module sim_vseg_classify;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        req_noexc = 1'b0;
   logic [1:0]  st_ksu = '0;
   logic        st_exl = 1'b0, st_erl = 1'b0;
   logic        st_ux = 1'b0, st_sx = 1'b0, st_kx = 1'b0;
   logic        rsp_valid, rsp_wide, rsp_tlb_req, rsp_direct, rsp_writable;
   logic        rsp_fail, rsp_exc;
   logic [1:0]  rsp_priv;
   logic [43:0] rsp_paddr;
   logic [4:0]  rsp_exc_code;
   logic [63:0] rsp_badaddr;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vseg_classify u0 (.*);

   typedef struct packed {
      logic [1:0]  priv;
      logic        wide;
      logic        tlb;
      logic        direct;
      logic        wr;
      logic [43:0] pa;
      logic        fail;
      logic        exc;
      logic [4:0]  code;
      logic [63:0] bad;
   } exp_t;

   string path_tag;

   function automatic exp_t model(logic [63:0] va, logic wr, logic nx, logic [1:0] ksu,
                                  logic exl, logic erl, logic ux, logic sx, logic kx);
      exp_t e = '0;
      logic [63:0] sx_va;
      e.priv = (exl | erl) ? 2'd0 : ksu;
      e.wide = (e.priv == 2'd0) ? kx : (e.priv == 2'd1) ? sx : ux;
      sx_va = (va < 64'h1_0000_0000 && va >= 64'h8000_0000) ? (va | 64'hFFFF_FFFF_0000_0000) : va;
      if (va >= 64'h8000_0000_0000_0000 && va < 64'hC000_0000_0000_0000) begin
         e.direct = 1; e.wr = 1; e.pa = va[43:0]; path_tag = "R3";
      end else if (va <= 64'h7FFF_FFFF) begin
         e.tlb = 1; path_tag = "R4";
      end else if (e.priv == 2'd0) begin
         if (sx_va >= 64'hFFFF_FFFF_8000_0000 && sx_va <= 64'hFFFF_FFFF_BFFF_FFFF) begin
            e.direct = 1; e.wr = 1; e.pa = 44'(sx_va & 64'h1FFF_FFFF); path_tag = "R6";
         end else begin
            e.tlb = 1; path_tag = "R7";
         end
      end else begin
         e.fail = 1;
         if (nx) path_tag = "R9";
         else begin
            e.exc = 1; e.code = wr ? 5'd5 : 5'd4; e.bad = sx_va; path_tag = "R8";
         end
      end
      if (sx_va != va && va[63:32] == 0) path_tag = {path_tag, "/R5"};
      return e;
   endfunction

   task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic request(logic [63:0] va, logic wr, logic nx, logic [1:0] ksu,
                          logic exl, logic erl, logic ux, logic sx, logic kx);
      exp_t e;
      e = model(va, wr, nx, ksu, exl, erl, ux, sx, kx);
      req_valid = 1; req_vaddr = va; req_write = wr; req_noexc = nx;
      st_ksu = ksu; st_exl = exl; st_erl = erl; st_ux = ux; st_sx = sx; st_kx = kx;
      @(negedge clk);
      req_valid = 0;
      check("R10", "valid", 64'(rsp_valid), 64'd1);
      check("R1", "priv", 64'(rsp_priv), 64'(e.priv));
      check("R2", "wide", 64'(rsp_wide), 64'(e.wide));
      check(path_tag, "tlb/direct/fail", 64'({rsp_tlb_req, rsp_direct, rsp_fail}),
            64'({e.tlb, e.direct, e.fail}));
      check(path_tag, "paddr/writable", 64'({rsp_writable, rsp_paddr}), 64'({e.wr, e.pa}));
      check(path_tag, "exc/code", 64'({rsp_exc, rsp_exc_code}), 64'({e.exc, e.code}));
      check(path_tag, "badaddr", rsp_badaddr, e.bad);
   endtask

   task automatic idle_check();
      @(negedge clk);
      check("R10", "idle strobes", 64'({rsp_valid, rsp_tlb_req, rsp_direct, rsp_fail, rsp_exc}), 64'd0);
   endtask

   function automatic logic [63:0] pick_addr(int fam);
      logic [63:0] r = {$urandom(), $urandom()};
      case (fam)
         0: return {33'd0, r[30:0]};
         1: return {32'd0, 1'b1, r[30:0]};
         2: return {32'hFFFF_FFFF, 2'b10, r[29:0]};
         3: return {2'b10, r[61:0]};
         4: return {32'hFFFF_FFFF, 2'b11, r[29:0]};
         default: return r;
      endcase
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1337));
      repeat (3) @(negedge clk);
      check("R10", "reset strobes", 64'({rsp_valid, rsp_tlb_req, rsp_exc, rsp_fail}), 64'd0);
      rst_n = 1;
      @(negedge clk);
      check("R10", "post-reset idle", 64'({rsp_valid, rsp_direct}), 64'd0);

      // directed corners
      request(64'h0000_0000_7FFF_FFFF, 0, 0, 2'b10, 0, 0, 1, 0, 0); // R4 boundary, user
      request(64'h0000_0000_8000_0000, 0, 0, 2'b00, 0, 0, 0, 0, 1); // R5 -> kernel direct pa 0
      request(64'h0000_0000_BFFF_FFFF, 1, 0, 2'b00, 0, 0, 0, 0, 0); // R6 top of window
      request(64'h0000_0000_C000_0000, 0, 0, 2'b00, 0, 0, 0, 0, 0); // R7 just above window
      request(64'h0000_0000_8000_0010, 1, 0, 2'b10, 0, 0, 0, 0, 0); // R8 store, R5 bad address
      request(64'hFFFF_FFFF_9000_0000, 0, 0, 2'b01, 0, 0, 0, 1, 0); // R8 load, supervisor
      request(64'hFFFF_FFFF_9000_0000, 1, 1, 2'b10, 0, 0, 0, 0, 0); // R9 probe
      request(64'h9000_0ABC_DEF0_1234, 1, 0, 2'b10, 0, 0, 1, 0, 0); // R3 user direct
      request(64'hBFFF_FFFF_FFFF_FFFF, 0, 0, 2'b00, 0, 0, 0, 0, 1); // R3 top
      request(64'hFFFF_FFFF_9000_0000, 0, 0, 2'b10, 1, 0, 0, 0, 1); // R1 exl override
      request(64'hFFFF_FFFF_9000_0000, 0, 0, 2'b11, 0, 1, 1, 0, 0); // R1 erl override
      request(64'h4000_0000_0000_0000, 1, 0, 2'b11, 0, 0, 1, 1, 0); // R2 mode 11 like user
      request(64'hC000_0000_0000_0000, 0, 0, 2'b00, 0, 0, 0, 0, 1); // R7 other kernel
      idle_check();

      for (int i = 0; i < 600; i++) begin
         logic [6:0] s = 7'($urandom());
         request(pick_addr(int'($urandom_range(0, 5))), s[0], ($urandom_range(0, 3) == 0),
                 s[2:1], ($urandom_range(0, 5) == 0), ($urandom_range(0, 7) == 0),
                 s[3], s[4], s[5]);
         if (s[6] && s[0]) idle_check();
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule